// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block drives the digital side of a 10-bit successive-approximation converter. Software sets a start bit. The block then either starts converting at once (manual mode) or first lets the sample-and-hold settle for a programmed number of conversion-clock periods. After that it walks a trial code from the most significant bit down to the least significant bit against an external comparator. When the walk ends, it stores the code, clears the start bit, raises a sticky interrupt flag and goes back to sampling the selected channel.

The conversion clock is an enable pulse taken from the system clock by a programmable divider. Every step of the sequence advances only on that pulse. The start bit also serves as the busy indication. Nothing outside the block can tell acquisition apart from conversion, apart from the hold output that the analog switch uses. The analog front end and the comparator are outside the block and appear only as ports.

Top module: `adc_seq`

## Requirements
- R1: `cclk_en` is high for one system-clock cycle in every `div_ratio`+1 cycles. With `div_ratio` = 0 it is high on every cycle.
- R2: For a nonzero acquisition code, `busy` stays high for exactly N+10 `cclk_en` pulses after the start write. N is 2, 4, 6, 8, 12, 16 or 20 for codes 1 through 7.
- R3: With acquisition code 0, `hold` is high in the cycle right after the start write is accepted, and `busy` lasts exactly 10 `cclk_en` pulses.
- R4: The acquisition code register resets to 0, so the first conversion after reset runs in manual mode.
- R5: `trial_code` starts at 10'h200 when conversion begins. One bit is decided per `cclk_en` pulse, from bit 9 down to bit 0. A bit is kept as 1 when `cmp_hi` is 1, where `cmp_hi` = 1 means the input is at or above `trial_code`. The final code equals the input level.
- R6: `result` changes only on the cycle where a conversion completes. It reads 0 after reset.
- R7: On completion, `busy` falls and `irq_flag` is set on the same clock edge.
- R8: `irq_flag` stays set until `flag_clr` is pulsed. A completion in the same cycle as `flag_clr` wins.
- R9: A start write while `busy` is high is ignored. The running conversion keeps its timing and result, and no extra conversion follows.
- R10: `hold` is high only during the 10 conversion pulses. It is low while sampling and while acquiring, and `trial_code` is 0 whenever `hold` is low.
- R11: `chan_sel` takes the value of `cfg_chan` on the cycle after a `cfg_we` write, even during a conversion, with no added delay. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_ratio | input | DIV_W | Conversion clock divide ratio minus one |
| cfg_we | input | 1 | Write strobe for acquisition code and channel |
| cfg_acq | input | 3 | Acquisition code to write |
| cfg_chan | input | CH_W | Channel number to write |
| go_set | input | 1 | Write 1 to the start bit |
| flag_clr | input | 1 | Write-clear of the interrupt flag |
| cmp_hi | input | 1 | Comparator: input at or above trial code |
| chan_sel | output | CH_W | Channel routed to sample-and-hold |
| cclk_en | output | 1 | Conversion clock enable pulse |
| hold | output | 1 | Sampling stopped, conversion running |
| trial_code | output | RES_W | Code presented to the comparator DAC |
| busy | output | 1 | Start/done bit readback |
| result | output | RES_W | Last completed conversion result |
| irq_flag | output | 1 | Sticky completion flag |

## Verification
The bench covers every acquisition code, manual mode straight out of reset, and the codes at both ends of the scale (0 and 1023), along with mid-scale neighbours 511 and 512. A wrong time table or a missing manual path would change the count of enable pulses during busy. A SAR step that picks the wrong bit or uses the wrong compare would give a code that differs from the driven level. A start write in mid-conversion is also tried. A design that accepted it would restart the count or queue a second completion, and the scoreboard would see the wrong duration or a completion it did not expect. The bench also checks that the flag stays set, that the result does not change during a conversion, and that a channel write takes effect while busy. These catch a flag that clears itself, a result that tracks the trial code, and a channel that waits for idle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_SAMPLE = 2'd0,
    ST_ACQ    = 2'd1,
    ST_CONV   = 2'd2
  } seq_state_t;

  localparam int ACQ_W = 5;

  // acquisition periods for a selector code; 0 means manual (none)
  function automatic logic [ACQ_W-1:0] acq_periods(input logic [2:0] code);
    logic [ACQ_W-1:0] n;
    case (code)
      3'd1:    n = 5'd2;
      3'd2:    n = 5'd4;
      3'd3:    n = 5'd6;
      3'd4:    n = 5'd8;
      3'd5:    n = 5'd12;
      3'd6:    n = 5'd16;
      3'd7:    n = 5'd20;
      default: n = 5'd0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/adc_clkdiv.sv
module adc_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_ratio,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = (cnt_q >= div_ratio);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_ratio != '0) |=> (!tick || div_ratio == '0)); // R1

endmodule

// File: rtl/adc_acq_timer.sv
module adc_acq_timer
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  logic [2:0] code,
  output logic       running,
  output logic       expired
);

  logic [ACQ_W-1:0] left_q;
  logic             run_q;

  assign running = run_q;
  assign expired = run_q && tick && (left_q == ACQ_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      run_q  <= 1'b0;
    end else if (load) begin
      left_q <= acq_periods(code);
      run_q  <= 1'b1;
    end else if (run_q && tick) begin
      left_q <= left_q - 1'b1;
      if (left_q == ACQ_W'(1)) run_q <= 1'b0;
    end
  end

  AST_ACQ_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (left_q != '0)); // R2
  AST_ACQ_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick && !load) |=> $stable(left_q)); // R2

endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             begin_i,
  input  logic             cmp_hi,
  output logic             active,
  output logic [RES_W-1:0] trial,
  output logic             done,
  output logic [RES_W-1:0] final_code
);

  localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
  localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] trial_q;
  logic             act_q;

  // decide bit at pos, then place the next trial bit below it
  function automatic logic [RES_W-1:0] sar_step(input logic [RES_W-1:0] c,
                                                input logic [IDX_W-1:0] pos,
                                                input logic keep);
    logic [RES_W-1:0] n;
    n = c;
    n[pos] = keep;
    if (pos != '0) n[pos - 1'b1] = 1'b1;
    return n;
  endfunction

  assign active     = act_q;
  assign trial      = trial_q;
  assign done       = act_q && tick && (idx_q == '0);
  assign final_code = sar_step(trial_q, idx_q, cmp_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      idx_q   <= '0;
      trial_q <= '0;
    end else if (begin_i) begin
      act_q   <= 1'b1;
      idx_q   <= TOP_IDX;
      trial_q <= MSB_ONE;
    end else if (act_q && tick) begin
      if (idx_q == '0) begin
        act_q   <= 1'b0;
        trial_q <= '0;
      end else begin
        trial_q <= sar_step(trial_q, idx_q, cmp_hi);
        idx_q   <= idx_q - 1'b1;
      end
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (idx_q <= TOP_IDX)); // R5
  AST_IDLE_TRIAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q |-> (trial_q == '0)); // R10

endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int DIV_W = 8,
  parameter int CH_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_acq,
  input  logic [CH_W-1:0]  cfg_chan,
  input  logic             go_set,
  input  logic             flag_clr,
  input  logic             cmp_hi,
  output logic [CH_W-1:0]  chan_sel,
  output logic             cclk_en,
  output logic             hold,
  output logic [RES_W-1:0] trial_code,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             irq_flag
);

  seq_state_t       state_q;
  logic [2:0]       acq_sel_q;
  logic [CH_W-1:0]  chan_q;
  logic [RES_W-1:0] result_q;
  logic             irq_q;

  // named internal events
  logic             tick;
  logic             go_ok;
  logic             start_manual;
  logic             start_timed;
  logic             acq_expired;
  logic             acq_running;
  logic             sar_begin;
  logic             sar_active;
  logic             conv_done;
  logic [RES_W-1:0] final_code;

  assign go_ok        = go_set && (state_q == ST_SAMPLE);
  assign start_manual = go_ok && (acq_sel_q == 3'd0);
  assign start_timed  = go_ok && (acq_sel_q != 3'd0);
  assign sar_begin    = start_manual || acq_expired;

  adc_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .tick(tick)
  );

  adc_acq_timer u_acq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(start_timed),
    .code(acq_sel_q), .running(acq_running), .expired(acq_expired)
  );

  adc_sar_core #(.RES_W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .tick(tick), .begin_i(sar_begin),
    .cmp_hi(cmp_hi), .active(sar_active), .trial(trial_code),
    .done(conv_done), .final_code(final_code)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acq_sel_q <= 3'd0;
      chan_q    <= '0;
    end else if (cfg_we) begin
      acq_sel_q <= cfg_acq;
      chan_q    <= cfg_chan;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_SAMPLE;
    end else begin
      case (state_q)
        ST_SAMPLE: if (start_manual) state_q <= ST_CONV;
                   else if (start_timed) state_q <= ST_ACQ;
        ST_ACQ:    if (acq_expired) state_q <= ST_CONV;
        ST_CONV:   if (conv_done) state_q <= ST_SAMPLE;
        default:   state_q <= ST_SAMPLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (conv_done) result_q <= final_code;
      if (conv_done)     irq_q <= 1'b1;
      else if (flag_clr) irq_q <= 1'b0;
    end
  end

  assign chan_sel = chan_q;
  assign cclk_en  = tick;
  assign hold     = sar_active;
  assign busy     = (state_q != ST_SAMPLE);
  assign result   = result_q;
  assign irq_flag = irq_q;

  AST_ACQ_IN_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    acq_running |-> (state_q == ST_ACQ)); // R2
  AST_MANUAL_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    start_manual |=> hold); // R3
  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done |=> $stable(result)); // R6
  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> irq_flag); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !flag_clr) |=> irq_flag); // R8
  AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_done) |=> busy); // R9
  AST_HOLD_MEANS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> busy); // R10
  AST_CHAN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (chan_sel == $past(cfg_chan))); // R11

endmodule

// File: tb/sim_adc_seq.sv
module sim_adc_seq;

  localparam int RES_W = 10;
  localparam int DIV_W = 8;
  localparam int CH_W  = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] div_ratio = 8'd2;
  logic             cfg_we = 1'b0;
  logic [2:0]       cfg_acq = 3'd0;
  logic [CH_W-1:0]  cfg_chan = '0;
  logic             go_set = 1'b0;
  logic             flag_clr = 1'b0;
  logic             cmp_hi;
  logic [CH_W-1:0]  chan_sel;
  logic             cclk_en;
  logic             hold;
  logic [RES_W-1:0] trial_code;
  logic             busy;
  logic [RES_W-1:0] result;
  logic             irq_flag;

  int vin = 0;
  int total = 0;
  int bad = 0;
  int exp_res[$];
  int exp_tk[$];

  always #4 clk = ~clk;

  // comparator model: input at or above trial code
  assign cmp_hi = (vin >= int'(trial_code));

  adc_seq #(.RES_W(RES_W), .DIV_W(DIV_W), .CH_W(CH_W)) u0 (
    .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .cfg_we(cfg_we),
    .cfg_acq(cfg_acq), .cfg_chan(cfg_chan), .go_set(go_set),
    .flag_clr(flag_clr), .cmp_hi(cmp_hi), .chan_sel(chan_sel),
    .cclk_en(cclk_en), .hold(hold), .trial_code(trial_code), .busy(busy),
    .result(result), .irq_flag(irq_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int acq_len(input int sel);
    if (sel == 0) return 0;
    if (sel <= 4) return 2 * sel;
    return 4 * sel - 8;
  endfunction

  // monitor: counts enable pulses while busy, compares at completion
  int  tk = 0;
  int  ht = 0;
  bit  prev_busy = 1'b0;
  bit  prev_hold = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        if (cclk_en) tk++;
        if (hold && cclk_en) ht++;
        if (hold && !prev_hold)
          chk(trial_code == 10'h200, "R5 first trial", int'(trial_code), 512);
      end else if (prev_busy) begin
        if (exp_res.size() == 0) begin
          chk(1'b0, "R9 unexpected completion", 1, 0);
        end else begin
          int er;
          int et;
          er = exp_res.pop_front();
          et = exp_tk.pop_front();
          chk(int'(result) == er, "R5 result", int'(result), er);
          chk(tk == et, "R2/R3 busy pulses", tk, et);
          chk(ht == 10, "R10 hold pulses", ht, 10);
          chk(irq_flag == 1'b1, "R7 flag at done", int'(irq_flag), 1);
        end
        tk = 0;
        ht = 0;
      end
      prev_busy = busy;
      prev_hold = hold;
    end
  end

  task automatic cfg(input int sel, input int ch);
    @(negedge clk);
    cfg_we = 1'b1; cfg_acq = 3'(sel); cfg_chan = CH_W'(ch);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_done();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_conv(input int sel, input int v);
    vin = v;
    exp_res.push_back(v);
    exp_tk.push_back(acq_len(sel) + 10);
    @(negedge clk);
    go_set = 1'b1;
    @(negedge clk);
    go_set = 1'b0;
    chk(hold == (sel == 0), "R3 hold after start", int'(hold), int'(sel == 0));
  endtask

  task automatic clear_flag();
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk(irq_flag == 1'b0, "R8 flag cleared", int'(irq_flag), 0);
  endtask

  task automatic period(input int d);
    int n;
    div_ratio = DIV_W'(d);
    repeat (8) @(negedge clk);
    while (!cclk_en) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cclk_en);
    chk(n == d + 1, "R1 enable period", n, d + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R7 busy reset", int'(busy), 0);
    chk(irq_flag == 1'b0, "R8 flag reset", int'(irq_flag), 0);
    chk(result == '0, "R6 result reset", int'(result), 0);
    chk(chan_sel == '0, "R11 chan reset", int'(chan_sel), 0);
    chk(hold == 1'b0 && trial_code == '0, "R10 idle outputs", int'(hold), 0);

    period(2);
    period(0);
    period(4);
    div_ratio = 8'd2;

    // R4: manual mode straight out of reset, no config write
    run_conv(0, 700);
    wait_done();

    // R8: flag stays until cleared
    repeat (20) @(negedge clk);
    chk(irq_flag == 1'b1, "R8 flag sticky", int'(irq_flag), 1);
    clear_flag();

    // R2: every acquisition code
    for (int s = 1; s < 8; s++) begin
      cfg(s, s);
      run_conv(s, (s * 137) % 1024);
      wait_done();
      clear_flag();
    end

    // R5 corner codes, manual, fast clock
    div_ratio = 8'd0;
    cfg(0, 3);
    run_conv(0, 0);    wait_done(); clear_flag();
    run_conv(0, 1023); wait_done(); clear_flag();
    run_conv(0, 512);  wait_done(); clear_flag();
    run_conv(0, 511);  wait_done(); clear_flag();

    // R6, R9, R11 during a timed conversion
    div_ratio = 8'd1;
    cfg(7, 4);
    run_conv(7, 341);
    repeat (12) @(negedge clk);
    chk(int'(result) == 511, "R6 result held mid-run", int'(result), 511);
    go_set = 1'b1;
    @(negedge clk);
    go_set = 1'b0;
    cfg_we = 1'b1; cfg_acq = 3'd7; cfg_chan = 5'd19;
    @(negedge clk);
    cfg_we = 1'b0;
    chk(chan_sel == 5'd19, "R11 chan during busy", int'(chan_sel), 19);
    chk(busy == 1'b1, "R9 still busy", int'(busy), 1);
    wait_done();
    repeat (100) @(negedge clk);
    chk(busy == 1'b0, "R9 no extra run", int'(busy), 0);
    chk(exp_res.size() == 0, "R9 queue drained", exp_res.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule